// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps one shared memory word coherent across a small group of cores. Each core owns a private single-line cache. The block holds, for every core, the MESI state of that line, the cached data and a data-valid flag, plus the memory word behind all the caches. Each core presents a request (read, write or evict) with a write value. A fixed-priority arbiter picks one request per cycle, and the block runs it as one atomic bus transaction. That transaction updates every cache and the memory word in the same clock edge.

A read miss takes its data from a dirty peer when one exists, and from memory otherwise. It ends in Exclusive when no peer holds a copy, and in Shared when one does. Writes gain ownership by invalidating the peers. A write to an Exclusive line upgrades with no bus activity. Evicting a dirty line writes it back to memory. The state of every line and the memory word are visible on output ports. A sticky error flag reports any break of the coherence invariants.

Top module: `mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0; codes are 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified, two bits per core with core i at bits [2i+1:2i]). Every data-valid flag is 0, memory is 0, no response is valid and the error flag is 0.
- R2: A read (op 00) by an Invalid core when no other core holds a valid copy loads the memory word and leaves the requester Exclusive.
- R3: A read miss when only Shared copies exist elsewhere loads the memory word and leaves the requester Shared. Other lines are unchanged.
- R4: A read miss while another core is Exclusive loads the memory word, and leaves both the requester and the former Exclusive holder Shared.
- R5: A read miss while another core is Modified copies the owner's data into memory and into the requester, and leaves both lines Shared.
- R6: A write (op 01) by an Invalid core first writes back any Modified peer's data to memory. It then makes the writer Modified with the new value, and every other line Invalid with its data cleared.
- R7: A write by a Shared core invalidates every other Shared copy, leaves memory unchanged and makes the writer Modified with the new value.
- R8: A write by an Exclusive core makes it Modified with no memory update. A write by a Modified core changes only its data.
- R9: An evict (op 1x) of a Modified line writes its data to memory and makes the line Invalid. An evict of a Shared or Exclusive line makes it Invalid with memory unchanged. An evict of an Invalid line changes nothing.
- R10: A read by a core in Shared, Exclusive or Modified returns its cached data and changes no line state and no memory.
- R11: Every accepted request produces a one-cycle response pulse on that core's response bit. A read's response carries the read data. Among simultaneous requests, the lowest core index is accepted that cycle. Every other requester sees busy and is accepted in a later cycle while it holds its request.
- R12: A Modified or Exclusive line always coexists with all other lines Invalid, and every Shared or Exclusive copy equals memory. A violation sets an error flag that only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_CORES | Request present, one bit per core |
| req_op_i | input | 2*NUM_CORES | Request opcode per core: 00 read, 01 write, 1x evict |
| req_wdata_i | input | NUM_CORES*DATA_W | Write value per core |
| req_ready_o | output | NUM_CORES | Request accepted this cycle |
| req_busy_o | output | NUM_CORES | Request pending but not accepted |
| rsp_valid_o | output | NUM_CORES | One-cycle completion pulse for the accepted core |
| rsp_data_o | output | DATA_W | Read data of the completed request |
| line_state_o | output | 2*NUM_CORES | Per-core line state |
| line_data_o | output | NUM_CORES*DATA_W | Per-core cached data |
| line_valid_o | output | NUM_CORES | Per-core data-valid flag |
| mem_o | output | DATA_W | Shared memory word |
| coh_err_o | output | 1 | Sticky coherence violation flag |

## Verification
The hardest case to reach is a read miss that has to pull dirty data from another core. A Modified line exists only after a write. Any later read miss then has to collide with it before an eviction or another writer takes it away. The stimulus table builds these histories on purpose. One sequence goes Shared, then upgrade, then a read miss against the new owner. Another goes Modified, then a read-for-ownership by a second core, so the dirty data moves into memory before the next owner overwrites it. Contention is driven by raising two requests in the same cycle and holding the loser's request until it is accepted.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  localparam logic [1:0] OP_RD = 2'b00;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mesi_arbiter.sv
module mesi_arbiter #(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0] req_i,
  output logic [NUM_CORES-1:0] gnt_o
);
  // isolate lowest set bit
  assign gnt_o = req_i & ~(req_i - NUM_CORES'(1));
endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
  import mesi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = $clog2(NUM_CORES)
) (
  input  line_st_e [NUM_CORES-1:0] st_i,
  input  logic [IDX_W-1:0]         self_i,
  output logic                     m_hit_o,
  output logic [IDX_W-1:0]         m_idx_o,
  output logic                     e_hit_o,
  output logic [IDX_W-1:0]         e_idx_o,
  output logic                     s_hit_o
);
  always_comb begin
    m_hit_o = 1'b0;
    m_idx_o = '0;
    e_hit_o = 1'b0;
    e_idx_o = '0;
    s_hit_o = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (IDX_W'(i) != self_i) begin
        unique case (st_i[i])
          ST_M: begin m_hit_o = 1'b1; m_idx_o = IDX_W'(i); end
          ST_E: begin e_hit_o = 1'b1; e_idx_o = IDX_W'(i); end
          ST_S: s_hit_o = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mesi_txn.sv
module mesi_txn
  import mesi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NUM_CORES)
) (
  input  logic                            fire_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [1:0]                      op_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  line_st_e [NUM_CORES-1:0]        st_i,
  input  logic [NUM_CORES-1:0][DATA_W-1:0] data_i,
  input  logic [NUM_CORES-1:0]            vld_i,
  input  logic [DATA_W-1:0]               mem_i,
  input  logic                            m_hit_i,
  input  logic [IDX_W-1:0]                m_idx_i,
  input  logic                            e_hit_i,
  input  logic [IDX_W-1:0]                e_idx_i,
  input  logic                            s_hit_i,
  output line_st_e [NUM_CORES-1:0]        st_o,
  output logic [NUM_CORES-1:0][DATA_W-1:0] data_o,
  output logic [NUM_CORES-1:0]            vld_o,
  output logic [DATA_W-1:0]               mem_o,
  output logic [DATA_W-1:0]               rdata_o
);
  line_st_e me;
  assign me = st_i[idx_i];

  always_comb begin
    st_o    = st_i;
    data_o  = data_i;
    vld_o   = vld_i;
    mem_o   = mem_i;
    rdata_o = data_i[idx_i];
    if (fire_i) begin
      if (op_i == OP_RD) begin
        if (me == ST_I) begin
          vld_o[idx_i] = 1'b1;
          if (m_hit_i) begin
            mem_o          = data_i[m_idx_i];
            data_o[idx_i]  = data_i[m_idx_i];
            rdata_o        = data_i[m_idx_i];
            st_o[m_idx_i]  = ST_S;
            st_o[idx_i]    = ST_S;
          end else begin
            data_o[idx_i] = mem_i;
            rdata_o       = mem_i;
            if (e_hit_i) begin
              st_o[e_idx_i] = ST_S;
              st_o[idx_i]   = ST_S;
            end else if (s_hit_i) begin
              st_o[idx_i] = ST_S;
            end else begin
              st_o[idx_i] = ST_E;
            end
          end
        end
      end else if (op_i == OP_WR) begin
        if (me == ST_I && m_hit_i) mem_o = data_i[m_idx_i];
        for (int j = 0; j < NUM_CORES; j++) begin
          if (IDX_W'(j) != idx_i && (me == ST_I || (me == ST_S && st_i[j] == ST_S))) begin
            st_o[j]   = ST_I;
            data_o[j] = '0;
            vld_o[j]  = 1'b0;
          end
        end
        st_o[idx_i]   = ST_M;
        data_o[idx_i] = wdata_i;
        vld_o[idx_i]  = 1'b1;
      end else begin
        if (me == ST_M) mem_o = data_i[idx_i];
        st_o[idx_i]   = ST_I;
        data_o[idx_i] = '0;
        vld_o[idx_i]  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NUM_CORES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CORES-1:0]          req_valid_i,
  input  logic [2*NUM_CORES-1:0]        req_op_i,
  input  logic [NUM_CORES*DATA_W-1:0]   req_wdata_i,
  output logic [NUM_CORES-1:0]          req_ready_o,
  output logic [NUM_CORES-1:0]          req_busy_o,
  output logic [NUM_CORES-1:0]          rsp_valid_o,
  output logic [DATA_W-1:0]             rsp_data_o,
  output logic [2*NUM_CORES-1:0]        line_state_o,
  output logic [NUM_CORES*DATA_W-1:0]   line_data_o,
  output logic [NUM_CORES-1:0]          line_valid_o,
  output logic [DATA_W-1:0]             mem_o,
  output logic                          coh_err_o
);
  logic [NUM_CORES-1:0][1:0]        op_a;
  logic [NUM_CORES-1:0][DATA_W-1:0] wd_a;
  assign op_a = req_op_i;
  assign wd_a = req_wdata_i;

  line_st_e [NUM_CORES-1:0]         st_q, st_d;
  logic [NUM_CORES-1:0][DATA_W-1:0] data_q, data_d;
  logic [NUM_CORES-1:0]             vld_q, vld_d;
  logic [DATA_W-1:0]                mem_q, mem_d, rdata;
  logic [NUM_CORES-1:0]             rsp_q;
  logic [DATA_W-1:0]                rsp_data_q;
  logic                             err_q, inv_bad;

  logic [NUM_CORES-1:0] gnt;
  logic [IDX_W-1:0]     idx;
  logic                 fire;
  logic                 m_hit, e_hit, s_hit;
  logic [IDX_W-1:0]     m_idx, e_idx;

  mesi_arbiter #(.NUM_CORES(NUM_CORES)) u_arb (
    .req_i(req_valid_i),
    .gnt_o(gnt)
  );

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_CORES; i++) if (gnt[i]) idx = IDX_W'(i);
  end
  assign fire = |gnt;

  mesi_snoop #(.NUM_CORES(NUM_CORES)) u_snoop (
    .st_i   (st_q),
    .self_i (idx),
    .m_hit_o(m_hit),
    .m_idx_o(m_idx),
    .e_hit_o(e_hit),
    .e_idx_o(e_idx),
    .s_hit_o(s_hit)
  );

  mesi_txn #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_txn (
    .fire_i (fire),
    .idx_i  (idx),
    .op_i   (op_a[idx]),
    .wdata_i(wd_a[idx]),
    .st_i   (st_q),
    .data_i (data_q),
    .vld_i  (vld_q),
    .mem_i  (mem_q),
    .m_hit_i(m_hit),
    .m_idx_i(m_idx),
    .e_hit_i(e_hit),
    .e_idx_i(e_idx),
    .s_hit_i(s_hit),
    .st_o   (st_d),
    .data_o (data_d),
    .vld_o  (vld_d),
    .mem_o  (mem_d),
    .rdata_o(rdata)
  );

  // invariant monitor on registered state
  logic [NUM_CORES-1:0] holds;
  always_comb begin
    inv_bad = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) holds[i] = (st_q[i] != ST_I);
    for (int i = 0; i < NUM_CORES; i++) begin
      if ((st_q[i] == ST_M || st_q[i] == ST_E) && ((holds & ~(NUM_CORES'(1) << i)) != '0))
        inv_bad = 1'b1;
      if ((st_q[i] == ST_S || st_q[i] == ST_E) && data_q[i] != mem_q)
        inv_bad = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= {NUM_CORES{ST_I}};
      data_q     <= '0;
      vld_q      <= '0;
      mem_q      <= '0;
      rsp_q      <= '0;
      rsp_data_q <= '0;
      err_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      data_q     <= data_d;
      vld_q      <= vld_d;
      mem_q      <= mem_d;
      rsp_q      <= gnt;
      rsp_data_q <= rdata;
      err_q      <= err_q | inv_bad;
    end
  end

  assign req_ready_o  = gnt;
  assign req_busy_o   = req_valid_i & ~gnt;
  assign rsp_valid_o  = rsp_q;
  assign rsp_data_o   = rsp_data_q;
  assign line_state_o = st_q;
  assign line_data_o  = data_q;
  assign line_valid_o = vld_q;
  assign mem_o        = mem_q;
  assign coh_err_o    = err_q;

  // R11
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o) && ((req_ready_o & ~req_valid_i) == '0));
  // R11
  grant_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i != '0) |-> (req_ready_o != '0));
  // R12
  no_coh_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !coh_err_o);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    // R12
    owner_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == ST_M || st_q[g] == ST_E) |-> ((holds & ~(NUM_CORES'(1) << g)) == '0));
    // R12
    clean_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == ST_S || st_q[g] == ST_E) |-> (data_q[g] == mem_q));
    // R8
    silent_upgrade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_ready_o[g] && op_a[g] == OP_WR && st_q[g] == ST_E)
      |=> (st_q[g] == ST_M && $stable(mem_q)));
    // R9
    dirty_evict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_ready_o[g] && op_a[g][1] && st_q[g] == ST_M)
      |=> (st_q[g] == ST_I && mem_q == $past(data_q[g])));
    // R6
    write_owns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_ready_o[g] && op_a[g] == OP_WR) |=> (st_q[g] == ST_M && rsp_valid_o[g]));
    // R10
    read_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_ready_o[g] && op_a[g] == OP_RD && st_q[g] != ST_I)
      |=> ($stable(st_q) && $stable(mem_q)));
  end
endmodule

// File: tb/tb_mesi_ctrl.sv
module tb_mesi_ctrl;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int NV = 20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    req_ready, req_busy, rsp_valid, line_valid;
  logic [DW-1:0]   rsp_data, mem;
  logic [2*N-1:0]  line_state;
  logic [N*DW-1:0] line_data;
  logic            coh_err;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mesi_ctrl #(.NUM_CORES(N), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .req_busy_o(req_busy),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .line_state_o(line_state), .line_data_o(line_data), .line_valid_o(line_valid),
    .mem_o(mem), .coh_err_o(coh_err)
  );

  // {req[3:0], core[1:0], op[1:0], wdata[7:0], states{c3,c2,c1,c0}[7:0], mem[7:0], rchk, rdata[7:0]}
  localparam logic [40:0] VEC [NV] = '{
    {4'd2,  2'd0, 2'b00, 8'h00, 8'b00_00_00_10, 8'h00, 1'b1, 8'h00}, // R2
    {4'd4,  2'd1, 2'b00, 8'h00, 8'b00_00_01_01, 8'h00, 1'b1, 8'h00}, // R4
    {4'd3,  2'd2, 2'b00, 8'h00, 8'b00_01_01_01, 8'h00, 1'b1, 8'h00}, // R3
    {4'd7,  2'd1, 2'b01, 8'h5A, 8'b00_00_11_00, 8'h00, 1'b0, 8'h00}, // R7
    {4'd5,  2'd3, 2'b00, 8'h00, 8'b01_00_01_00, 8'h5A, 1'b1, 8'h5A}, // R5
    {4'd10, 2'd3, 2'b00, 8'h00, 8'b01_00_01_00, 8'h5A, 1'b1, 8'h5A}, // R10
    {4'd6,  2'd0, 2'b01, 8'h33, 8'b00_00_00_11, 8'h5A, 1'b0, 8'h00}, // R6
    {4'd8,  2'd0, 2'b01, 8'h44, 8'b00_00_00_11, 8'h5A, 1'b0, 8'h00}, // R8
    {4'd6,  2'd2, 2'b01, 8'h77, 8'b00_11_00_00, 8'h44, 1'b0, 8'h00}, // R6
    {4'd10, 2'd2, 2'b00, 8'h00, 8'b00_11_00_00, 8'h44, 1'b1, 8'h77}, // R10
    {4'd9,  2'd2, 2'b10, 8'h00, 8'b00_00_00_00, 8'h77, 1'b0, 8'h00}, // R9
    {4'd2,  2'd1, 2'b00, 8'h00, 8'b00_00_10_00, 8'h77, 1'b1, 8'h77}, // R2
    {4'd8,  2'd1, 2'b01, 8'h12, 8'b00_00_11_00, 8'h77, 1'b0, 8'h00}, // R8
    {4'd9,  2'd1, 2'b11, 8'h00, 8'b00_00_00_00, 8'h12, 1'b0, 8'h00}, // R9
    {4'd2,  2'd3, 2'b00, 8'h00, 8'b10_00_00_00, 8'h12, 1'b1, 8'h12}, // R2
    {4'd9,  2'd3, 2'b10, 8'h00, 8'b00_00_00_00, 8'h12, 1'b0, 8'h00}, // R9
    {4'd2,  2'd0, 2'b00, 8'h00, 8'b00_00_00_10, 8'h12, 1'b1, 8'h12}, // R2
    {4'd4,  2'd1, 2'b00, 8'h00, 8'b00_00_01_01, 8'h12, 1'b1, 8'h12}, // R4
    {4'd9,  2'd0, 2'b10, 8'h00, 8'b00_00_01_00, 8'h12, 1'b0, 8'h00}, // R9
    {4'd9,  2'd2, 2'b10, 8'h00, 8'b00_00_01_00, 8'h12, 1'b0, 8'h00}  // R9 evict of Invalid
  };

  task automatic check(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int core, input logic [1:0] op, input logic [DW-1:0] wd);
    req_valid[core] = 1'b1;
    req_op[2*core +: 2] = op;
    req_wdata[DW*core +: DW] = wd;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, "reset state", 64'(line_state), 64'd0);
    check(1, "reset valid", 64'(line_valid), 64'd0);
    check(1, "reset mem", 64'(mem), 64'd0);
    check(1, "reset rsp", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      int rq, core;
      rq   = int'(VEC[k][40:37]);
      core = int'(VEC[k][36:35]);
      drive(core, VEC[k][34:33], VEC[k][32:25]);
      @(negedge clk);
      req_valid = '0;
      check(rq, $sformatf("vec %0d states", k), 64'(line_state), 64'(VEC[k][24:17]));
      check(rq, $sformatf("vec %0d mem", k), 64'(mem), 64'(VEC[k][16:9]));
      // R11 response pulse to the accepted core
      check(11, $sformatf("vec %0d rsp", k), 64'(rsp_valid), 64'(1 << core));
      if (VEC[k][8]) check(rq, $sformatf("vec %0d rdata", k), 64'(rsp_data), 64'(VEC[k][7:0]));
      @(negedge clk);
    end

    // R11 contention: cores 1 and 3 read together, state {I,I,S,I}
    drive(1, 2'b00, 8'h00);
    drive(3, 2'b00, 8'h00);
    #5;
    check(11, "grant lowest", 64'(req_ready), 64'b0010);
    check(11, "busy loser", 64'(req_busy), 64'b1000);
    @(negedge clk);
    req_valid[1] = 1'b0;
    check(10, "hit rdata c1", 64'(rsp_data), 64'h12);
    #5;
    check(11, "held request granted", 64'(req_ready), 64'b1000);
    check(11, "no busy after", 64'(req_busy), 64'b0000);
    @(negedge clk);
    req_valid = '0;
    check(3, "late reader shared", 64'(line_state), 64'b01_00_01_00);
    check(11, "late rsp", 64'(rsp_valid), 64'b1000);
    check(12, "error flag low", 64'(coh_err), 64'd0);
    // R1 reset again clears everything
    rst_n = 1'b0;
    #5;
    check(1, "reset clears state", 64'(line_state), 64'd0);
    check(1, "reset clears mem", 64'(mem), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule